// File: doc/BRIEF.md
# Receive Dribble-Bit Nibble Trimmer

This block sits on the receive path of a 10 Mbps Ethernet port. Its input is a recovered serial bit stream, qualified by a frame-active level. Its output is a 4-bit nibble receive interface with a data-valid strobe. In nibble mode it packs incoming bits into nibbles with the least-significant bit first and presents each completed nibble for one cycle.

When the frame-active level drops, the block examines the bits that arrived after the last whole byte. A few leftover bits (one to three, beyond any complete nibble) become one final nibble, and ones fill its unused positions. A leftover count of five to seven leaves only the complete first nibble on the interface, and the partial second nibble is dropped. At most one odd nibble therefore follows the last whole byte, so a MAC that truncates to byte boundaries still computes a correct CRC.

A mode input selects serial forwarding instead. In that mode every accepted bit is presented on nibble bit 0 with no trimming and no padding.

Top module: `rxdb_trimmer`

## Requirements
- R1: A synchronous active-high reset clears the bit counter, the shift register, the nibble output and data-valid. Data-valid stays low after any clock edge that samples reset high, and the nibble output is 0.
- R2: In nibble mode a bit is accepted on a clock edge where both bitValid and frameActive are high. The k-th accepted bit of a nibble (k = 0..3) appears on rxNibble[k]. The nibble is presented together with rxValid after the edge that accepts its fourth bit.
- R3: In nibble mode rxValid is a one-cycle pulse for each presented nibble and is low in every other cycle.
- R4: End of frame is an edge that samples frameActive low after an edge that sampled it high. When the number of accepted bits is a multiple of 8, no nibble follows the last full nibble.
- R5: When the number of accepted bits modulo 8 is 1, 2 or 3, exactly one final nibble is presented after the end-of-frame edge. It carries those bits in positions 0 upward.
- R6: In that final nibble, every bit position above the received bits is 1.
- R7: When the accepted count modulo 8 is 4, the last nibble is the full nibble already presented when its fourth bit arrived. Nothing is added at end of frame.
- R8: When the accepted count modulo 8 is 5, 6 or 7, the complete first nibble of the residue is presented. The partial second nibble is never presented.
- R9: In serial mode each accepted bit is presented after its edge as rxNibble = {3'b000, bit} with rxValid high for that cycle. There is no padding and no end-of-frame nibble.
- R10: A bit offered while frameActive is low, or in a cycle with bitValid low, is not accepted and produces no rxValid.
- R11: A new frame may begin on the edge right after the end-of-frame edge. The bit count restarts at zero, so the new frame's first bit lands in position 0 even while the previous frame's padded nibble is being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Recovered receive bit |
| bitValid | input | 1 | bitIn holds a new bit this cycle |
| frameActive | input | 1 | High for the duration of the frame's data |
| serialMode | input | 1 | 1: forward bits one at a time; 0: nibble assembly |
| rxNibble | output | 4 | Receive nibble, bit 0 received first |
| rxValid | output | 1 | rxNibble is valid this cycle |

## Verification
Two functions can fall in the same cycle: presenting the padded end-of-frame nibble of one frame, and capturing the first bit of the next frame. The bench provokes this by dropping frameActive for a single cycle between two frames, the first of which ends with two leftover bits. It judges the result by comparing the whole nibble sequence of both frames against one computed sequence: the padded nibble must be intact, and the second frame's nibbles must start from position 0. The sweep over every residue 0 to 7, in both modes and with and without idle gaps between bits, covers the remaining end-of-frame decisions.

// File: rtl/rxdb_pkg.sv
package rxdb_pkg;
  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic capture;      // write the incoming bit into the shift register
    logic emitFull;     // present the nibble completed by this bit
    logic emitPartial;  // present the padded residue nibble at end of frame
    logic emitSerial;   // present the incoming bit alone (serial mode)
  } rxdbStrobe_t;
endpackage

// File: rtl/rxdb_ctrl.sv
module rxdb_ctrl
  import rxdb_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bitValid,
  input  logic                       frameActive,
  input  logic                       serialMode,
  output rxdbStrobe_t                strobe,
  output logic [$clog2(NIB_W)-1:0]   slotIdx
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int POS_W  = $clog2(NIB_W);

  logic             frameD;
  logic [CNT_W-1:0] bitCount;
  logic             take;
  logic             endOfFrame;
  logic             smallResidue;

  assign take         = bitValid & frameActive;
  assign endOfFrame   = frameD & ~frameActive;
  assign slotIdx      = bitCount[POS_W-1:0];
  assign smallResidue = (bitCount != '0) && (bitCount < CNT_W'(NIB_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      frameD   <= 1'b0;
      bitCount <= '0;
    end else begin
      frameD <= frameActive;
      if (endOfFrame || serialMode)
        bitCount <= '0;
      else if (take)
        bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strobe.capture     = take & ~serialMode;
    strobe.emitFull    = take & ~serialMode & (slotIdx == POS_W'(NIB_W - 1));
    strobe.emitPartial = endOfFrame & ~serialMode & smallResidue;
    strobe.emitSerial  = take & serialMode;
  end
endmodule

// File: rtl/rxdb_datapath.sv
module rxdb_datapath
  import rxdb_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bitIn,
  input  rxdbStrobe_t                strobe,
  input  logic [$clog2(NIB_W)-1:0]   slotIdx,
  output logic [NIB_W-1:0]           rxNibble,
  output logic                       rxValid
);
  logic [NIB_W-1:0] shiftReg;
  logic [NIB_W-1:0] merged;
  logic [NIB_W-1:0] padded;

  // merged: shift register with the incoming bit in its slot
  // padded: received residue bits, ones from the next slot upward
  always_comb begin
    merged          = shiftReg;
    merged[slotIdx] = bitIn;
    for (int i = 0; i < NIB_W; i++)
      padded[i] = (i >= int'(slotIdx)) ? 1'b1 : shiftReg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      rxNibble <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (strobe.capture)
        shiftReg <= merged;
      rxValid <= strobe.emitFull | strobe.emitPartial | strobe.emitSerial;
      if (strobe.emitFull)
        rxNibble <= merged;
      else if (strobe.emitPartial)
        rxNibble <= padded;
      else if (strobe.emitSerial)
        rxNibble <= {{(NIB_W-1){1'b0}}, bitIn};
    end
  end
endmodule

// File: rtl/rxdb_trimmer.sv
module rxdb_trimmer
  import rxdb_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitIn,
  input  logic             bitValid,
  input  logic             frameActive,
  input  logic             serialMode,
  output logic [NIB_W-1:0] rxNibble,
  output logic             rxValid
);
  localparam int POS_W = $clog2(NIB_W);

  rxdbStrobe_t      strobe;
  logic [POS_W-1:0] slotIdx;

  rxdb_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bitValid    (bitValid),
    .frameActive (frameActive),
    .serialMode  (serialMode),
    .strobe      (strobe),
    .slotIdx     (slotIdx)
  );

  rxdb_datapath #(.NIB_W(NIB_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .bitIn    (bitIn),
    .strobe   (strobe),
    .slotIdx  (slotIdx),
    .rxNibble (rxNibble),
    .rxValid  (rxValid)
  );
endmodule

// File: rtl/rxdb_checker.sv
module rxdb_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bitIn,
  input logic             bitValid,
  input logic             frameActive,
  input logic             serialMode,
  input logic [NIB_W-1:0] rxNibble,
  input logic             rxValid
);
  logic frameSeen, prevTake, prevEof, prevBit, prevSerial;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameSeen  <= 1'b0;
      prevTake   <= 1'b0;
      prevEof    <= 1'b0;
      prevBit    <= 1'b0;
      prevSerial <= 1'b0;
    end else begin
      frameSeen  <= frameActive;
      prevTake   <= bitValid & frameActive;
      prevEof    <= frameSeen & ~frameActive;
      prevBit    <= bitIn;
      prevSerial <= serialMode;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rxValid && rxNibble == '0));

  assert_valid_cause_R10: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> (prevTake || prevEof));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !serialMode && !prevSerial) |=> (!rxValid || serialMode));

  assert_pad_top_R6: assert property (@(posedge clk) disable iff (rst)
    (rxValid && prevEof && !prevSerial) |-> rxNibble[NIB_W-1]);

  assert_serial_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (rxValid && prevTake && prevSerial) |-> (rxNibble == {{(NIB_W-1){1'b0}}, prevBit}));
endmodule

bind rxdb_trimmer rxdb_checker #(.NIB_W(NIB_W)) i_rxdb_checker (
  .clk         (clk),
  .rst         (rst),
  .bitIn       (bitIn),
  .bitValid    (bitValid),
  .frameActive (frameActive),
  .serialMode  (serialMode),
  .rxNibble    (rxNibble),
  .rxValid     (rxValid)
);

// File: tb/test_rxdb_trimmer.sv
`timescale 1ns/1ps
module test_rxdb_trimmer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitIn = 1'b0;
  logic       bitValid = 1'b0;
  logic       frameActive = 1'b0;
  logic       serialMode = 1'b0;
  logic [3:0] rxNibble;
  logic       rxValid;

  int testsRun = 0;
  int testsFailed = 0;
  logic [3:0] gotQ[$];
  logic [3:0] expQ[$];

  always #2.5 clk = ~clk;

  rxdb_trimmer #(.NIB_W(4)) i_rxdb_trimmer (
    .clk(clk), .rst(rst), .bitIn(bitIn), .bitValid(bitValid),
    .frameActive(frameActive), .serialMode(serialMode),
    .rxNibble(rxNibble), .rxValid(rxValid)
  );

  always @(negedge clk)
    if (!rst && rxValid) gotQ.push_back(rxNibble);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic bitOf(input int seed, input int i);
    int v;
    v = seed * 131 + i * 29 + (i * i) % 7;
    return ^v[7:0];
  endfunction

  task automatic addExpected(input int n, input int seed, input logic ser);
    logic [3:0] nib;
    int r;
    if (ser) begin
      for (int i = 0; i < n; i++) expQ.push_back({3'b000, bitOf(seed, i)});
    end else begin
      for (int k = 0; k < n / 4; k++) begin
        for (int j = 0; j < 4; j++) nib[j] = bitOf(seed, 4 * k + j);
        expQ.push_back(nib);
      end
      r = n % 8;
      if (r >= 1 && r <= 3) begin
        for (int j = 0; j < 4; j++) nib[j] = (j < r) ? bitOf(seed, 4 * (n / 4) + j) : 1'b1;
        expQ.push_back(nib);
      end
    end
  endtask

  task automatic driveBits(input int n, input int seed, input logic gaps);
    frameActive = 1'b1;
    for (int i = 0; i < n; i++) begin
      bitValid = 1'b1;
      bitIn = bitOf(seed, i);
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        bitValid = 1'b0;
        bitIn = ~bitIn;
        @(negedge clk);
      end
    end
    bitValid = 1'b0;
  endtask

  task automatic compareQ(input string tag);
    check(gotQ.size() == expQ.size(), {tag, " nibble count"}, gotQ.size(), expQ.size());
    if (gotQ.size() == expQ.size())
      for (int i = 0; i < expQ.size(); i++)
        check(gotQ[i] == expQ[i], {tag, " nibble value"}, gotQ[i], expQ[i]);
    gotQ.delete();
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R1: outputs after reset
    check(rxValid == 1'b0, "R1 rxValid after reset", rxValid, 0);
    check(rxNibble == 4'h0, "R1 rxNibble after reset", rxNibble, 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: bits offered with frameActive low are ignored
    for (int i = 0; i < 6; i++) begin
      bitValid = 1'b1; bitIn = i[0];
      @(negedge clk);
    end
    bitValid = 1'b0;
    @(negedge clk);
    check(gotQ.size() == 0, "R10 no output with frameActive low", gotQ.size(), 0);

    // R2 timing: bits 1,0,1,1 -> nibble 4'b1101 after the edge taking the 4th bit
    frameActive = 1'b1;
    bitValid = 1'b1; bitIn = 1'b1; @(negedge clk);
    bitIn = 1'b0; @(negedge clk);
    bitIn = 1'b1; @(negedge clk);
    bitIn = 1'b1; @(negedge clk);
    bitValid = 1'b0;
    check(rxValid == 1'b1, "R2 valid after 4th bit", rxValid, 1);
    check(rxNibble == 4'hD, "R2 LSB-first packing", rxNibble, 13);
    @(negedge clk);
    check(rxValid == 1'b0, "R3 pulse one cycle", rxValid, 0);
    frameActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(rxValid == 1'b0, "R7 no nibble at end with residue 4", rxValid, 0);
    gotQ.delete();

    // R5 timing: bits 0,1 then end -> padded 4'b1110 right after the end edge
    @(negedge clk);
    frameActive = 1'b1;
    bitValid = 1'b1; bitIn = 1'b0; @(negedge clk);
    bitIn = 1'b1; @(negedge clk);
    bitValid = 1'b0; frameActive = 1'b0;
    @(negedge clk);
    check(rxValid == 1'b1, "R5 residue nibble after end edge", rxValid, 1);
    check(rxNibble == 4'hE, "R6 padding with ones", rxNibble, 14);
    @(negedge clk);
    check(rxValid == 1'b0, "R3 residue pulse one cycle", rxValid, 0);
    gotQ.delete();

    // Sweep: residues 0..7, several lengths, both modes, with and without gaps
    for (int ser = 0; ser < 2; ser++)
      for (int gaps = 0; gaps < 2; gaps++)
        for (int b = 0; b < 3; b++)
          for (int r = 0; r < 8; r++) begin
            int n;
            int seed;
            n = 8 * (b * 2 + b / 2) + r;
            seed = ser * 97 + gaps * 41 + b * 13 + r;
            if (ser == 1)      tag = "R9 serial";
            else if (r == 0)   tag = "R4 residue 0";
            else if (r <= 3)   tag = "R5 R6 residue 1-3";
            else if (r == 4)   tag = "R7 residue 4";
            else               tag = "R8 residue 5-7";
            serialMode = ser[0];
            @(negedge clk);
            addExpected(n, seed, ser[0]);
            driveBits(n, seed, gaps[0]);
            frameActive = 1'b0;
            repeat (4) @(negedge clk);
            compareQ(tag);
          end

    // R11: back-to-back frames with a single low cycle between them
    serialMode = 1'b0;
    @(negedge clk);
    addExpected(18, 5, 1'b0);
    addExpected(13, 9, 1'b0);
    driveBits(18, 5, 1'b0);
    frameActive = 1'b0;
    @(negedge clk);
    driveBits(13, 9, 1'b0);
    frameActive = 1'b0;
    repeat (4) @(negedge clk);
    compareQ("R11 back-to-back frames");

    // R1: reset mid-frame clears partial state
    frameActive = 1'b1;
    bitValid = 1'b1; bitIn = 1'b1; @(negedge clk);
    @(negedge clk);
    bitValid = 1'b0;
    rst = 1'b1; frameActive = 1'b0;
    @(negedge clk);
    check(rxValid == 1'b0, "R1 reset clears valid", rxValid, 0);
    rst = 1'b0;
    @(negedge clk);
    gotQ.delete();
    addExpected(4, 3, 1'b0);
    driveBits(4, 3, 1'b0);
    frameActive = 1'b0;
    repeat (4) @(negedge clk);
    compareQ("R1 count restarts after reset");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule